// File: doc/BRIEF.md
# 64-bit Wall Clock with Tear-Free High-Word Capture

This block keeps a 64-bit time counter that advances by one on every clock cycle while it is enabled. The counter is read through a simple word-wide memory-mapped bus as 32-bit halves. A read of the low half also copies the high half of the same counter value into a shadow register, so software reads the low word first and then the shadow word to get one coherent 64-bit time. A second location gives the high half as it is now, which may have moved on since the low read.

One more location holds a configuration word that software writes once during setup (the value 63 is typical). Bit 0 of that word is the count enable, and the whole word reads back. The bus takes one request per cycle with no back-pressure. A small two-state responder answers each request one cycle later. In state `ST_IDLE` no response is pending. An accepted request moves it to `ST_RESP` (transition `T_ACCEPT`), where `rsp_valid` is high. From `ST_RESP` a new request keeps it there (`T_CHAIN`), and no request returns it to `ST_IDLE` (`T_DRAIN`).

Top module: `wclk_top`

## Requirements
- R1: While reset is low and on the first cycle after it, the counter equals the START_VALUE parameter, the shadow high word is 0, the configuration word is 32'h1 (counting on) and `rsp_valid` is 0.
- R2: When configuration bit 0 is 1, the counter rises by exactly one per clock. When that bit is 0, the counter holds its value.
- R3: A read at offset 0x1F0 returns counter bits 31:0. The value is the counter as it stood on the clock edge that accepted the request, and it is presented with `rsp_valid` on the following cycle.
- R4: The same read at 0x1F0 copies counter bits 63:32 of that same counter value into the shadow register. A read at offset 0x1F8 returns the shadow register.
- R5: A read at offset 0x1F4 returns the live counter bits 63:32 at the accepting edge.
- R6: When the low word wraps from all ones to zero, the high word increments on the same clock edge.
- R7: A write at offset 0x024 stores all 32 data bits into the configuration word, which reads back at 0x024. Bit 0 governs counting from the next clock edge onward.
- R8: Writes to 0x1F0, 0x1F4 and 0x1F8 change neither the counter nor the shadow register. The shadow register changes only on a read of 0x1F0.
- R9: Every accepted request, read or write, gets `rsp_valid` high exactly one cycle later. Write responses and reads of unmapped offsets return 0.
- R10: The responder follows `ST_IDLE`/`ST_RESP` with transitions `T_ACCEPT`, `T_CHAIN` and `T_DRAIN`, so back-to-back requests give back-to-back responses in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_rdata | output | 32 | Read data (0 for writes) |

## Verification
The counter starts 32 cycles below a low-word wrap. This exercises the carry into the high word: a design that let the carry lag a cycle would show a high word one too small beside a small low word. The bench reads the shadow word both before and after the wrap. A shadow that followed the live high word, or that was captured a cycle late, would show up there as a value one too large.

The bench also clears the enable and checks that the counter stays frozen, which catches a design that ignores bit 0. It writes to the counter locations and checks that nothing moves. Back-to-back reads of the low word and the shadow word confirm that the responder does not drop or reorder a response while chaining.

// File: rtl/wclk_pkg.sv
package wclk_pkg;
    localparam int unsigned DATA_W = 32;

    localparam logic [11:0] OFF_LOW    = 12'h1F0;
    localparam logic [11:0] OFF_HIGH   = 12'h1F4;
    localparam logic [11:0] OFF_SHADOW = 12'h1F8;
    localparam logic [11:0] OFF_CFG    = 12'h024;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/wclk_counter.sv
module wclk_counter #(
    parameter int unsigned        CNT_W       = 64,
    parameter int unsigned        WORD_W      = 32,
    parameter logic [CNT_W-1:0]   START_VALUE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);
    localparam int unsigned NW = CNT_W / WORD_W;

    // carry[i] = increment request into word i
    logic [NW-1:0] carry;
    assign carry[0] = en;

    for (genvar gi = 0; gi < NW; gi++) begin : g_w
        logic [WORD_W-1:0] w_q;

        always_ff @(posedge clk) begin
            if (!rst_n)
                w_q <= START_VALUE[gi*WORD_W +: WORD_W];
            else if (carry[gi])
                w_q <= w_q + 1'b1;
        end

        assign cnt[gi*WORD_W +: WORD_W] = w_q;

        if (gi < NW - 1) begin : g_c
            assign carry[gi+1] = carry[gi] & (&w_q);
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> cnt == $past(cnt) + 1'b1); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt)); // R2
    AST_CARRY_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (&cnt[WORD_W-1:0])) |=>
            (cnt[2*WORD_W-1:WORD_W] == $past(cnt[2*WORD_W-1:WORD_W]) + 1'b1)); // R6
endmodule

// File: rtl/wclk_regbank.sv
module wclk_regbank
    import wclk_pkg::*;
#(
    parameter int unsigned      CNT_W     = 64,
    parameter int unsigned      ADDR_W    = 12,
    parameter logic [DATA_W-1:0] CFG_RESET = 32'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cnt,
    output logic              count_en,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] cfg_q;
    logic              rd_low;
    logic              wr_cfg;

    assign rd_low = req_valid && !req_write && (req_addr == ADDR_W'(OFF_LOW));
    assign wr_cfg = req_valid &&  req_write && (req_addr == ADDR_W'(OFF_CFG));

    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (rd_low)
            shadow_q <= cnt[2*DATA_W-1:DATA_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (wr_cfg)
            cfg_q <= req_wdata;
    end

    assign count_en = cfg_q[0];

    always_comb begin
        rd_data = '0;
        if (req_valid && !req_write) begin
            case (req_addr)
                ADDR_W'(OFF_LOW):    rd_data = cnt[DATA_W-1:0];
                ADDR_W'(OFF_HIGH):   rd_data = cnt[2*DATA_W-1:DATA_W];
                ADDR_W'(OFF_SHADOW): rd_data = shadow_q;
                ADDR_W'(OFF_CFG):    rd_data = cfg_q;
                default:             rd_data = '0;
            endcase
        end
    end

    AST_SHADOW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_low |=> shadow_q == $past(cnt[2*DATA_W-1:DATA_W])); // R4
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_low |=> $stable(shadow_q)); // R8
    AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> cfg_q == $past(req_wdata)); // R7
endmodule

// File: rtl/wclk_top.sv
module wclk_top
    import wclk_pkg::*;
#(
    parameter int unsigned      CNT_W       = 64,
    parameter int unsigned      ADDR_W      = 12,
    parameter logic [CNT_W-1:0] START_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    logic [CNT_W-1:0]  cnt;
    logic              count_en;
    logic [DATA_W-1:0] rd_data;
    rsp_state_e        state_q, state_d;

    wclk_counter #(
        .CNT_W      (CNT_W),
        .WORD_W     (DATA_W),
        .START_VALUE(START_VALUE)
    ) u_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (count_en),
        .cnt  (cnt)
    );

    wclk_regbank #(
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W)
    ) u_regbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .cnt      (cnt),
        .count_en (count_en),
        .rd_data  (rd_data)
    );

    // T_ACCEPT: IDLE->RESP, T_CHAIN: RESP->RESP, T_DRAIN: RESP->IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_rdata <= '0;
        else if (req_valid)
            rsp_rdata <= rd_data;
    end

    assign rsp_valid = (state_q == ST_RESP);

    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R9
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
endmodule

// File: tb/wclk_top_bench.sv
module wclk_top_bench;
    localparam logic [63:0] START = 64'h0000_0002_FFFF_FFE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    logic [63:0] model_cnt;
    logic        model_en;
    logic [31:0] model_cfg;
    logic [31:0] model_shadow;

    always #10 clk = ~clk;

    wclk_top #(.START_VALUE(START)) u_wclk_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

    // reference model of the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            model_cnt <= START;
            model_cfg <= 32'h1;
        end else begin
            model_cnt <= model_cnt + (model_cfg[0] ? 64'd1 : 64'd0);
            if (req_valid && req_write && req_addr == 12'h024)
                model_cfg <= req_wdata;
        end
    end
    assign model_en = model_cfg[0];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: called at a negedge, issues one request and pushes its expectation
    task automatic rd(input logic [11:0] a, input string tag);
        logic [31:0] e;
        case (a)
            12'h1F0: begin e = model_cnt[31:0]; model_shadow = model_cnt[63:32]; end
            12'h1F4: e = model_cnt[63:32];
            12'h1F8: e = model_shadow;
            12'h024: e = model_cfg;
            default: e = 32'h0;
        endcase
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        exp_q.push_back(32'h0); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9: actual=unexpected response expected=none");
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        model_shadow = 32'h0;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h1F8, "R1 shadow after reset");
        rd(12'h024, "R1 cfg after reset");
        rd(12'h1F0, "R3 low word");
        rd(12'h1F8, "R4 shadow after low read");
        rd(12'h1F4, "R5 live high");
        idle(3);
        rd(12'h1F0, "R2 low word advanced");
        idle(40);
        rd(12'h1F4, "R6 live high after wrap");
        rd(12'h1F8, "R8 shadow unchanged by other reads");
        rd(12'h1F0, "R6 low word after wrap");
        rd(12'h1F8, "R4 shadow after second low read");
        wr(12'h024, 32'd63, "R9 write response zero");
        rd(12'h024, "R7 cfg readback");
        wr(12'h024, 32'h0, "R9 write response zero");
        rd(12'h1F0, "R2 frozen low");
        idle(5);
        rd(12'h1F0, "R2 still frozen low");
        wr(12'h1F0, 32'h0, "R9 write response zero");
        wr(12'h1F8, 32'hDEAD_BEEF, "R9 write response zero");
        rd(12'h1F0, "R8 low unchanged by write");
        rd(12'h1F4, "R8 high unchanged by write");
        rd(12'h1F8, "R8 shadow unchanged by write");
        rd(12'h100, "R9 unmapped reads zero");
        wr(12'h024, 32'h1, "R9 write response zero");
        idle(4);
        rd(12'h1F0, "R10 chained low");
        rd(12'h1F8, "R10 chained shadow");
        rd(12'h1F4, "R10 chained high");
        idle(3);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R9: actual=%0d pending expected=0 pending", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule